// File: doc/BRIEF.md
# Banked GPIO and Pin-Function Controller

This block controls a parameterised number of general-purpose pins through a 32-bit register port. Pins are grouped into banks of 32, and every register class is repeated once per bank. Software raises and lowers outputs only through a pair of atomic set and clear words. The output value can be read back. A direction word decides which pins drive, and each pad input passes through a two-flop synchroniser before it can be read.

Each pin carries a two-bit function code that is split bit-wise across two parallel select registers and brought out as a per-pin function index. Code 0 means plain GPIO; codes 1 to 3 pick alternate functions. Every change of a pin's synchronised input, rising or falling, sets a sticky status flag that software clears by writing one. An enable mask gates the flags into a read-only identity view, and the OR of that view drives one combined interrupt line.

Top module: `gpmx_top`

## Requirements
- R1: While reset is low, and after it is released, every register is zero: `pad_out`, `pad_oe` and `pin_func` are all zero, `irq` is low, and every mapped word reads zero.
- R2: With `STRIDE = 1 + (NUM_PINS-1)/32`, the word for register class c and bank b is at byte address `4*(c*STRIDE + b)`. Pin p uses bit `p mod 32` of bank `p/32`. The class indices are: set 0, clear 1, output 2, input 3, direction 4, status 5, enable 6, identity 7, select-low 8, select-high 9.
- R3: A write to the set word makes every output bit written as 1 go to 1 on the next clock. Bits written as 0 keep their value.
- R4: A write to the clear word makes every output bit written as 1 go to 0 on the next clock. Bits written as 0 keep their value.
- R5: Output bits change only through the set and clear words. Writes to the output word are ignored, and the set and clear words read as zero.
- R6: The direction word is read/write. Bit value 1 drives the pin (`pad_oe` high), and 0 makes it an input.
- R7: `pin_func[2p+1:2p]` equals {select-high bit p, select-low bit p}.
- R8: The input word shows `pad_in` after exactly two clock edges through a two-flop synchroniser.
- R9: A status bit is set one clock after a change, in either direction, appears in the input word. It is set whether or not the pin is enabled, and it stays set until software clears it.
- R10: Writing 1 to a status bit clears it, and writing 0 has no effect. A new change in the same cycle as the clearing write wins, and the bit stays set.
- R11: The identity word reads as status AND enable, per bank, and ignores writes.
- R12: `irq` is the OR of all identity bits in all banks.
- R13: Unmapped addresses read zero and ignore writes. Register bits for pins at or above `NUM_PINS` read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | ADDR_W | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pad_in | input | NUM_PINS | Asynchronous pad inputs |
| pad_out | output | NUM_PINS | Output value per pin |
| pad_oe | output | NUM_PINS | Output enable per pin |
| pin_func | output | 2*NUM_PINS | Two-bit function index per pin |
| irq | output | 1 | Combined interrupt |

## Verification
The bench uses 40 pins, which gives a full bank and a partial bank, so the stride formula and the masking of absent pins are both tested. Set and clear words are written with overlapping and with zero masks, which separates real atomic updates from plain overwrites and from writes that have no effect. Pad changes are sampled one edge early and on the expected edge, rising and falling, on enabled and disabled pins. This pins down the synchroniser latency and shows that the status flag does not depend on the enable mask. A clearing write placed in the same cycle as a fresh change distinguishes which of the two takes priority.

// File: rtl/gpmx_pkg.sv
// Package: shared constants and types for the banked GPIO controller.
// Assumes a 32-bit register port and 32 pins per bank.
package gpmx_pkg;
    localparam int BANK_W  = 32;
    localparam int NUM_CLS = 10;

    // Register class index; multiplied by the bank stride to form the word address.
    typedef enum logic [3:0] {
        CLS_SET   = 4'd0,
        CLS_CLR   = 4'd1,
        CLS_OUT   = 4'd2,
        CLS_IN    = 4'd3,
        CLS_OE    = 4'd4,
        CLS_IST   = 4'd5,
        CLS_IEN   = 4'd6,
        CLS_IDENT = 4'd7,
        CLS_SEL0  = 4'd8,
        CLS_SEL1  = 4'd9
    } reg_cls_e;

    // Per-bank write strobes produced by the decoder.
    typedef struct packed {
        logic set;
        logic clr;
        logic oe;
        logic ist;
        logic ien;
        logic sel0;
        logic sel1;
    } bank_wr_t;

    // Per-bank register view returned to the read mux.
    typedef struct packed {
        logic [BANK_W-1:0] outv;
        logic [BANK_W-1:0] inv;
        logic [BANK_W-1:0] oe;
        logic [BANK_W-1:0] ist;
        logic [BANK_W-1:0] ien;
        logic [BANK_W-1:0] sel0;
        logic [BANK_W-1:0] sel1;
    } bank_view_t;
endpackage

// File: rtl/gpmx_sync.sv
// Module: two-flop synchroniser for the pad inputs.
// Assumes the inputs are asynchronous level signals; it does not filter glitches.
module gpmx_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    // Shift the asynchronous pad levels through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d;
            stage2_q <= stage1_q;
        end
    end

    assign q = stage2_q;
endmodule

// File: rtl/gpmx_decode.sv
// Module: address decoder. Splits the byte address into a register class and
// a bank index, using word = class*STRIDE + bank, and produces per-bank write strobes.
// Assumes address bits [1:0] are ignored and ADDR_W is at least 6.
module gpmx_decode
    import gpmx_pkg::*;
#(
    parameter int STRIDE     = 2,
    parameter int ADDR_W     = 8,
    parameter int BANK_IDX_W = 1
) (
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    output logic                  hit,
    output reg_cls_e              cls,
    output logic [BANK_IDX_W-1:0] bank_sel,
    output bank_wr_t              wr_vec [STRIDE]
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    logic [WORD_W-1:0] cls_num;
    logic [WORD_W-1:0] bank_num;

    // Split the word index into class and bank.
    always_comb begin
        word     = bus_addr[ADDR_W-1:2];
        cls_num  = word / WORD_W'(STRIDE);
        bank_num = word % WORD_W'(STRIDE);
        hit      = (cls_num < WORD_W'(NUM_CLS));
        cls      = hit ? reg_cls_e'(cls_num[3:0]) : CLS_SET;
        bank_sel = BANK_IDX_W'(bank_num);
    end

    for (genvar b = 0; b < STRIDE; b++) begin : g_strobe
        logic sel_b;
        assign sel_b = bus_wr && hit && (bank_num == WORD_W'(b));

        // Raise the write strobe of the addressed class for this bank only.
        always_comb begin
            wr_vec[b].set  = sel_b && (cls == CLS_SET);
            wr_vec[b].clr  = sel_b && (cls == CLS_CLR);
            wr_vec[b].oe   = sel_b && (cls == CLS_OE);
            wr_vec[b].ist  = sel_b && (cls == CLS_IST);
            wr_vec[b].ien  = sel_b && (cls == CLS_IEN);
            wr_vec[b].sel0 = sel_b && (cls == CLS_SEL0);
            wr_vec[b].sel1 = sel_b && (cls == CLS_SEL1);
        end
    end
endmodule

// File: rtl/gpmx_bank.sv
// Module: register set for one 32-pin bank: outputs, direction, interrupt
// status and enable, and the two function-select words. Bits outside
// VALID_MASK (absent pins) are held at zero.
// Assumes sync_in is already synchronised to clk.
module gpmx_bank
    import gpmx_pkg::*;
#(
    parameter logic [BANK_W-1:0] VALID_MASK = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] sync_in,
    input  bank_wr_t          wr,
    input  logic [BANK_W-1:0] wdata,
    output bank_view_t        view
);
    logic [BANK_W-1:0] out_q, oe_q, ist_q, ien_q, sel0_q, sel1_q, prev_q;
    logic [BANK_W-1:0] wmask;
    logic [BANK_W-1:0] change;
    logic [BANK_W-1:0] w1c;

    assign wmask  = wdata & VALID_MASK;
    assign change = (sync_in ^ prev_q) & VALID_MASK;
    assign w1c    = wr.ist ? wmask : '0;

    // Output value: atomic set and clear only.
    always_ff @(posedge clk) begin
        if (!rst_n)      out_q <= '0;
        else if (wr.set) out_q <= out_q | wmask;
        else if (wr.clr) out_q <= out_q & ~wmask;
    end

    // Direction and function-select words: plain read/write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q   <= '0;
            sel0_q <= '0;
            sel1_q <= '0;
            ien_q  <= '0;
        end else begin
            if (wr.oe)   oe_q   <= wmask;
            if (wr.sel0) sel0_q <= wmask;
            if (wr.sel1) sel1_q <= wmask;
            if (wr.ien)  ien_q  <= wmask;
        end
    end

    // Previous synchronised level, for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_in & VALID_MASK;
    end

    // Sticky status: write-one-to-clear, a new change wins over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) ist_q <= '0;
        else        ist_q <= (ist_q & ~w1c) | change;
    end

    assign view.outv = out_q;
    assign view.inv  = sync_in & VALID_MASK;
    assign view.oe   = oe_q;
    assign view.ist  = ist_q;
    assign view.ien  = ien_q;
    assign view.sel0 = sel0_q;
    assign view.sel1 = sel1_q;
endmodule

// File: rtl/gpmx_top.sv
// Module: banked GPIO and pin-function controller top level.
// Instantiates the input synchroniser, the address decoder and one register
// bank per 32 pins, then assembles the read mux and the pin-level outputs.
// Assumes single-cycle writes and combinational reads on the register port.
module gpmx_top
    import gpmx_pkg::*;
#(
    parameter int NUM_PINS = 40,
    parameter int ADDR_W   = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic [NUM_PINS-1:0]   pad_in,
    output logic [NUM_PINS-1:0]   pad_out,
    output logic [NUM_PINS-1:0]   pad_oe,
    output logic [2*NUM_PINS-1:0] pin_func,
    output logic                  irq
);
    localparam int STRIDE     = 1 + (NUM_PINS - 1) / BANK_W;
    localparam int ALL_W      = STRIDE * BANK_W;
    localparam int BANK_IDX_W = (STRIDE > 1) ? $clog2(STRIDE) : 1;

    logic [NUM_PINS-1:0]   pad_sync;
    logic [ALL_W-1:0]      sync_wide;
    logic [ALL_W-1:0]      out_all, oe_all, ist_all, ien_all, sel0_all, sel1_all;
    logic                  hit;
    reg_cls_e              cls;
    logic [BANK_IDX_W-1:0] bank_sel;
    bank_wr_t              wr_vec [STRIDE];
    bank_view_t            views  [STRIDE];

    gpmx_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (pad_sync)
    );

    assign sync_wide = ALL_W'(pad_sync);

    gpmx_decode #(
        .STRIDE     (STRIDE),
        .ADDR_W     (ADDR_W),
        .BANK_IDX_W (BANK_IDX_W)
    ) u_decode (
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .hit      (hit),
        .cls      (cls),
        .bank_sel (bank_sel),
        .wr_vec   (wr_vec)
    );

    for (genvar b = 0; b < STRIDE; b++) begin : g_bank
        localparam int PINS_HERE = ((NUM_PINS - b * BANK_W) >= BANK_W) ?
                                   BANK_W : (NUM_PINS - b * BANK_W);
        localparam logic [BANK_W-1:0] MASK = (PINS_HERE == BANK_W) ? '1 :
                                   ((BANK_W'(1) << PINS_HERE) - BANK_W'(1));

        gpmx_bank #(.VALID_MASK(MASK)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .sync_in (sync_wide[b*BANK_W +: BANK_W]),
            .wr      (wr_vec[b]),
            .wdata   (bus_wdata),
            .view    (views[b])
        );

        assign out_all [b*BANK_W +: BANK_W] = views[b].outv;
        assign oe_all  [b*BANK_W +: BANK_W] = views[b].oe;
        assign ist_all [b*BANK_W +: BANK_W] = views[b].ist;
        assign ien_all [b*BANK_W +: BANK_W] = views[b].ien;
        assign sel0_all[b*BANK_W +: BANK_W] = views[b].sel0;
        assign sel1_all[b*BANK_W +: BANK_W] = views[b].sel1;
    end

    // Select the addressed word of the addressed bank; unmapped reads give zero.
    always_comb begin
        bus_rdata = '0;
        if (hit) begin
            case (cls)
                CLS_OUT:   bus_rdata = views[bank_sel].outv;
                CLS_IN:    bus_rdata = views[bank_sel].inv;
                CLS_OE:    bus_rdata = views[bank_sel].oe;
                CLS_IST:   bus_rdata = views[bank_sel].ist;
                CLS_IEN:   bus_rdata = views[bank_sel].ien;
                CLS_IDENT: bus_rdata = views[bank_sel].ist & views[bank_sel].ien;
                CLS_SEL0:  bus_rdata = views[bank_sel].sel0;
                CLS_SEL1:  bus_rdata = views[bank_sel].sel1;
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign pad_out = out_all[NUM_PINS-1:0];
    assign pad_oe  = oe_all[NUM_PINS-1:0];

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_func
        assign pin_func[2*p +: 2] = {sel1_all[p], sel0_all[p]};
    end

    assign irq = |(ist_all & ien_all);
endmodule

// File: rtl/gpmx_chk.sv
// Module: assertion checker for gpmx_top, attached by bind below.
// Assumes the top-level register layout described in the brief.
module gpmx_chk #(
    parameter int NUM_PINS = 40,
    parameter int STRIDE   = 2,
    parameter int ADDR_W   = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   bus_wr,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic [31:0]            bus_wdata,
    input logic [NUM_PINS-1:0]    pad_out,
    input logic                   irq,
    input logic [STRIDE*32-1:0]   ist_all,
    input logic [STRIDE*32-1:0]   ien_all
);
    localparam logic [ADDR_W-1:0] SET0  = '0;
    localparam logic [ADDR_W-1:0] CLR0  = ADDR_W'(4 * STRIDE);
    localparam logic [ADDR_W-1:0] OUTLO = ADDR_W'(8 * STRIDE);
    localparam logic [31:0] M0 = (NUM_PINS >= 32) ? 32'hFFFF_FFFF :
                                 ((32'd1 << NUM_PINS) - 32'd1);

    logic [STRIDE*32-1:0] out_full;
    logic [31:0]          out0;
    assign out_full = (STRIDE*32)'(pad_out);
    assign out0     = out_full[31:0];

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> (pad_out == '0 && irq == 1'b0));

    // R3
    set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == SET0) |=>
        ((out0 & $past(bus_wdata & M0)) == $past(bus_wdata & M0)));

    // R4
    clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == CLR0) |=> ((out0 & $past(bus_wdata)) == 32'd0));

    // R5
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr < OUTLO) |=> $stable(pad_out));

    // R9
    status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ((ist_all & $past(ist_all)) == $past(ist_all)));

    // R12
    irq_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (|(ist_all & ien_all)));
endmodule

bind gpmx_top gpmx_chk #(
    .NUM_PINS (NUM_PINS),
    .STRIDE   (STRIDE),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pad_out   (pad_out),
    .irq       (irq),
    .ist_all   (ist_all),
    .ien_all   (ien_all)
);

// File: tb/gpmx_top_test.sv
`timescale 1ns/1ps
module gpmx_top_test;
    localparam int NP = 40;
    localparam int AW = 8;
    localparam int ST = 1 + (NP - 1) / 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out, pad_oe;
    logic [2*NP-1:0] pin_func;
    logic          irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    gpmx_top #(.NUM_PINS(NP), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pin_func(pin_func), .irq(irq)
    );

    // Byte address of class c, bank b (R2).
    function automatic logic [AW-1:0] ra(input int c, input int b);
        return AW'(4 * (c * ST + b));
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int c, input int b, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = ra(c, b); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int c, input int b, output logic [31:0] d);
        bus_addr = ra(c, b);
        #0.5;
        d = bus_rdata;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 pad_out", 64'(pad_out), 64'd0);
        check("R1 pad_oe", 64'(pad_oe), 64'd0);
        check("R1 pin_func", 64'(pin_func), 64'd0);
        check("R1 irq", 64'(irq), 64'd0);
        for (int c = 0; c < 10; c++) begin
            for (int b = 0; b < ST; b++) begin
                rd(c, b, d);
                check("R1 word", 64'(d), 64'd0);
            end
        end
    endtask

    task automatic t_set_clr();
        logic [31:0] d;
        wr(0, 0, 32'h0000_00F0);
        check("R3 set bank0", 64'(pad_out), 64'h0F0);
        wr(1, 0, 32'h0000_0030);
        check("R4 clear bank0", 64'(pad_out), 64'h0C0);
        wr(0, 0, 32'h0);
        check("R3 zero set no change", 64'(pad_out), 64'h0C0);
        wr(1, 0, 32'h0);
        check("R4 zero clear no change", 64'(pad_out), 64'h0C0);
        wr(0, 1, 32'h0000_0180);
        check("R2 set bank1 pin39", 64'(pad_out), 64'h80_0000_00C0);
        rd(2, 1, d);
        check("R13 absent pin bit", 64'(d), 64'h80);
        rd(2, 0, d);
        check("R5 output readback", 64'(d), 64'hC0);
    endtask

    task automatic t_out_ro();
        logic [31:0] d;
        wr(2, 0, 32'hFFFF_FFFF);
        check("R5 output word write ignored", 64'(pad_out), 64'h80_0000_00C0);
        rd(0, 0, d);
        check("R5 set word reads zero", 64'(d), 64'd0);
        rd(1, 0, d);
        check("R5 clear word reads zero", 64'(d), 64'd0);
    endtask

    task automatic t_oe();
        logic [31:0] d;
        wr(4, 0, 32'h0000_00A5);
        wr(4, 1, 32'hFFFF_FF81);
        check("R6 pad_oe", 64'(pad_oe), 64'h81_0000_00A5);
        rd(4, 1, d);
        check("R13 oe bank1 masked", 64'(d), 64'h81);
        wr(4, 0, 32'h0);
        check("R6 oe to input", 64'(pad_oe), 64'h81_0000_0000);
    endtask

    task automatic t_func();
        wr(8, 0, 32'h0000_0088);
        wr(9, 0, 32'h0000_0028);
        wr(8, 1, 32'h0000_0002);
        check("R7 pin3 code3", 64'(pin_func[7:6]), 64'd3);
        check("R7 pin5 code2", 64'(pin_func[11:10]), 64'd2);
        check("R7 pin7 code1", 64'(pin_func[15:14]), 64'd1);
        check("R7 pin33 code1", 64'(pin_func[67:66]), 64'd1);
        check("R7 pin0 gpio", 64'(pin_func[1:0]), 64'd0);
    endtask

    task automatic t_input_sync();
        logic [31:0] d;
        @(negedge clk); pad_in[10] = 1'b1;
        wait_n(1);
        rd(3, 0, d);
        check("R8 not yet after one edge", 64'(d[10]), 64'd0);
        wait_n(1);
        rd(3, 0, d);
        check("R8 visible after two edges", 64'(d[10]), 64'd1);
        rd(5, 0, d);
        check("R9 status not yet", 64'(d[10]), 64'd0);
        wait_n(1);
        rd(5, 0, d);
        check("R9 status set disabled pin", 64'(d), 64'h400);
        rd(7, 0, d);
        check("R11 identity masked", 64'(d), 64'd0);
        check("R12 irq low disabled", 64'(irq), 64'd0);
        wr(5, 0, 32'hFFFF_FFFF);
    endtask

    task automatic t_irq_edges();
        logic [31:0] d;
        wr(6, 0, 32'h4);
        @(negedge clk); pad_in[2] = 1'b1;
        wait_n(3);
        rd(5, 0, d);
        check("R9 rising sets status", 64'(d), 64'h4);
        rd(7, 0, d);
        check("R11 identity", 64'(d), 64'h4);
        check("R12 irq high", 64'(irq), 64'd1);
        wr(5, 0, 32'h0);
        rd(5, 0, d);
        check("R10 write zero no effect", 64'(d), 64'h4);
        wr(7, 0, 32'h0);
        rd(7, 0, d);
        check("R11 identity write ignored", 64'(d), 64'h4);
        wr(5, 0, 32'h4);
        rd(5, 0, d);
        check("R10 write one clears", 64'(d), 64'h0);
        check("R12 irq low after clear", 64'(irq), 64'd0);
        @(negedge clk); pad_in[2] = 1'b0;
        wait_n(3);
        rd(5, 0, d);
        check("R9 falling sets status", 64'(d), 64'h4);
    endtask

    task automatic t_collision();
        logic [31:0] d;
        @(negedge clk); pad_in[2] = 1'b1;
        wait_n(1);
        wr(5, 0, 32'h4);
        rd(5, 0, d);
        check("R10 event wins over clear", 64'(d), 64'h4);
        check("R12 irq after collision", 64'(irq), 64'd1);
        wr(5, 0, 32'h4);
        rd(5, 0, d);
        check("R10 later clear", 64'(d), 64'h0);
    endtask

    task automatic t_bank1_irq();
        logic [31:0] d;
        wr(6, 1, 32'h10);
        @(negedge clk); pad_in[36] = 1'b1;
        wait_n(3);
        rd(7, 1, d);
        check("R2 bank1 identity pin36", 64'(d), 64'h10);
        rd(7, 0, d);
        check("R11 bank0 identity clear", 64'(d), 64'd0);
        check("R12 irq from bank1", 64'(irq), 64'd1);
        wr(5, 1, 32'h10);
        check("R12 irq low", 64'(irq), 64'd0);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        rd(10, 0, d);
        check("R13 unmapped read", 64'(d), 64'd0);
        wr(10, 0, 32'hFFFF_FFFF);
        wr(11, 1, 32'hFFFF_FFFF);
        check("R13 unmapped write pad_out", 64'(pad_out), 64'h80_0000_00C0);
        check("R13 unmapped write pad_oe", 64'(pad_oe), 64'h81_0000_0000);
    endtask

    initial begin
        wait_n(4);
        t_reset();
        rst_n = 1'b1;
        wait_n(2);
        t_reset();
        t_set_clr();
        t_out_ro();
        t_oe();
        t_func();
        t_input_sync();
        t_irq_edges();
        t_collision();
        t_bank1_irq();
        t_unmapped();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end
endmodule